// File: doc/BRIEF.md
# GPIO Bank with Edge-Event Latching

This block is a bank of up to 32 general-purpose pins behind a simple word-addressed register bus. Software picks a 3-bit function code for every pin, drives output pins through an output data register that is modified only by separate set and clear words, reads back the synchronized pin levels, and arms per-pin rising and falling edge detection. Detected edges are held in an event word that software clears by writing ones. An optional interrupt line is high while any event is pending.

Alternate functions are not routed inside the block. Each pin's function code is presented on a port, and an outside multiplexer uses it to pick the pad source. The output enable is driven only for pins coded as plain outputs.

Reads are combinational from the address. Writes take effect at the clock edge where `wr_en` is high. Pin inputs cross a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one clock earlier.

Top module: `gpio_evt_bank`

## Requirements
- R1: After reset every register reads zero. All function codes are 000 (input), `pin_oe` and `pin_out` are zero, and `irq` is low.
- R2: The function code of pin p lives in the select word at address p/10, bits (p mod 10)*3 +: 3. Bits 30 and 31 of every select word read zero. Fields for pins that do not exist also read zero.
- R3: A write to a select word updates all ten fields from the written data. A field whose written value equals its old value is left unchanged. A select word changes only when it is written, and `pin_fsel` shows each pin's code.
- R4: A write to address 4 (set word) sets each output data bit whose data bit is 1. Zero bits have no effect. Reading address 4 returns the output data register.
- R5: A write to address 5 (clear word) clears each output data bit whose data bit is 1. Zero bits have no effect. Reading address 5 returns the output data register.
- R6: `pin_out` equals the output data register. `pin_oe[p]` is high exactly when pin p's code is 001. The codes 000 (input), 100, 011 and 010 (alternate functions) and the rest leave `pin_oe` low.
- R7: Address 6 returns the synchronized pin level whatever function is selected. A pin change becomes visible after two clock edges, not after one.
- R8: Address 7 holds the rising-edge enables and address 8 the falling-edge enables, one bit per pin at bit p. An enabled edge sets event bit p on the third clock edge after the pin changes. An edge whose enable is clear sets nothing. With both enables set, either edge is caught.
- R9: Address 9 reads the event word. Writing 1 to a bit clears it. Writing 0 leaves it as it was.
- R10: If an enabled edge is detected in the same cycle that a write of 1 clears that event bit, the bit stays set.
- R11: With `HAS_IRQ`=1, `irq` is high exactly while some event bit is set. With `HAS_IRQ`=0, `irq` is tied low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pin_out | output | NUM_PINS | Output data register |
| pin_oe | output | NUM_PINS | Output enable, high for pins coded as output |
| pin_fsel | output | NUM_PINS*3 | Function code per pin, pin p at bits p*3 +: 3 |
| irq | output | 1 | High while any event is pending |

## Verification
The two functions that can meet in one cycle are edge detection and the software clear of the event word. The bench changes a pin at a falling clock edge and counts two rising edges. It then places a write of 1 to that event bit so that the write is captured at the third rising edge, which is the same edge at which the detector reports the new edge. The bit is judged by reading the event word afterwards: it must still be set. A second clear with no edge pending must then drop it and lower `irq`.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

   localparam int FSEL_W = 3;

   typedef enum logic [FSEL_W-1:0] {
      FN_INPUT  = 3'b000,
      FN_OUTPUT = 3'b001,
      FN_ALT_E  = 3'b010,
      FN_ALT_D  = 3'b011,
      FN_ALT_A  = 3'b100,
      FN_ALT_B  = 3'b101,
      FN_ALT_C  = 3'b110,
      FN_ALT_F  = 3'b111
   } pin_fn_e;

   // word addresses of the single-word registers (select words start at 0)
   localparam int A_OUT_SET = 4;
   localparam int A_OUT_CLR = 5;
   localparam int A_LEVEL   = 6;
   localparam int A_RISE_EN = 7;
   localparam int A_FALL_EN = 8;
   localparam int A_EVENTS  = 9;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
   import gpio_evt_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_idx,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [ADDR_W-1:0]          rd_idx,
   output logic [DATA_W-1:0]          rd_word,
   output logic [NUM_PINS*FSEL_W-1:0] fsel_flat
);

   localparam int PER_REG = DATA_W / FSEL_W;

   logic [FSEL_W-1:0] fld [NUM_PINS];

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_field
      localparam int REG = p / PER_REG;
      localparam int OFF = (p % PER_REG) * FSEL_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                fld[p] <= FN_INPUT;
         else if (wr_en && wr_idx == ADDR_W'(REG))  fld[p] <= wdata[OFF +: FSEL_W];
      end
      assign fsel_flat[p*FSEL_W +: FSEL_W] = fld[p];
   end

   always_comb begin
      rd_word = '0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (rd_idx == ADDR_W'(p / PER_REG))
            rd_word[(p % PER_REG)*FSEL_W +: FSEL_W] = fld[p];
      end
   end

endmodule

// File: rtl/gpio_edge_evt.sv
module gpio_edge_evt #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] rise_en,
   input  logic [W-1:0] fall_en,
   input  logic         clr_wr,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] lvl_prev,
   output logic [W-1:0] det,
   output logic [W-1:0] evt
);

   logic [W-1:0] clr_bits;

   assign det      = (lvl & ~lvl_prev & rise_en) | (~lvl & lvl_prev & fall_en);
   assign clr_bits = clr_wr ? clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_prev <= '0;
         evt      <= '0;
      end else begin
         lvl_prev <= lvl;
         evt      <= (evt & ~clr_bits) | det;   // a fresh edge wins over the clear
      end
   end

endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
   import gpio_evt_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_IRQ     = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   input  logic [NUM_PINS-1:0]        pin_in,
   output logic [NUM_PINS-1:0]        pin_out,
   output logic [NUM_PINS-1:0]        pin_oe,
   output logic [NUM_PINS*FSEL_W-1:0] pin_fsel,
   output logic                       irq
);

   localparam int PER_REG = DATA_W / FSEL_W;
   localparam int NSEL    = (NUM_PINS + PER_REG - 1) / PER_REG;
   localparam logic [ADDR_W-1:0] NSEL_A = ADDR_W'(NSEL);

   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..DATA_W");
   end
   if (DATA_W < 30) begin : g_bad_data
      $error("DATA_W must hold ten select fields");
   end
   if (ADDR_W < 4 || NSEL > A_OUT_SET) begin : g_bad_addr
      $error("address map does not fit");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] out_q, rise_q, fall_q;
   logic [NUM_PINS-1:0] lvl_sync, lvl_prev, det, evt_q;
   logic [DATA_W-1:0]   fsel_rd;
   logic [NUM_PINS-1:0] wbits;
   logic                sel_wr;
   logic                unused_bits;

   assign wbits       = wdata[NUM_PINS-1:0];
   assign sel_wr      = wr_en && (addr < NSEL_A);
   assign unused_bits = ^wdata;

   gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl_sync)
   );

   gpio_fsel_bank #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fsel (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_wr), .wr_idx(addr), .wdata(wdata),
      .rd_idx(addr), .rd_word(fsel_rd), .fsel_flat(pin_fsel)
   );

   gpio_edge_evt #(.W(NUM_PINS)) u_evt (
      .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .rise_en(rise_q), .fall_en(fall_q),
      .clr_wr(wr_en && addr == ADDR_W'(A_EVENTS)), .clr_mask(wbits),
      .lvl_prev(lvl_prev), .det(det), .evt(evt_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (wr_en) begin
         unique case (addr)
            ADDR_W'(A_OUT_SET): out_q  <= out_q | wbits;
            ADDR_W'(A_OUT_CLR): out_q  <= out_q & ~wbits;
            ADDR_W'(A_RISE_EN): rise_q <= wbits;
            ADDR_W'(A_FALL_EN): fall_q <= wbits;
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (addr < NSEL_A) rdata = fsel_rd;
      else begin
         unique case (addr)
            ADDR_W'(A_OUT_SET), ADDR_W'(A_OUT_CLR): rdata = DATA_W'(out_q);
            ADDR_W'(A_LEVEL):   rdata = DATA_W'(lvl_sync);
            ADDR_W'(A_RISE_EN): rdata = DATA_W'(rise_q);
            ADDR_W'(A_FALL_EN): rdata = DATA_W'(fall_q);
            ADDR_W'(A_EVENTS):  rdata = DATA_W'(evt_q);
            default:            rdata = '0;
         endcase
      end
   end

   assign pin_out = out_q;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_oe
      assign pin_oe[p] = (pin_fsel[p*FSEL_W +: FSEL_W] == FN_OUTPUT);
   end

   if (HAS_IRQ) begin : g_irq
      assign irq = |evt_q;
   end else begin : g_no_irq
      assign irq = 1'b0;
   end

endmodule

// File: rtl/gpio_evt_bank_chk.sv
module gpio_evt_bank_chk
   import gpio_evt_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [ADDR_W-1:0]          addr,
   input logic [NUM_PINS-1:0]        wbits,
   input logic [NUM_PINS-1:0]        out_q,
   input logic [NUM_PINS-1:0]        evt_q,
   input logic [NUM_PINS-1:0]        det,
   input logic [NUM_PINS-1:0]        lvl_sync,
   input logic [NUM_PINS-1:0]        lvl_prev,
   input logic [NUM_PINS*FSEL_W-1:0] fsel_flat,
   input logic                       irq
);

   localparam int PER_REG = DATA_W / FSEL_W;
   localparam int NSEL    = (NUM_PINS + PER_REG - 1) / PER_REG;

   // R3
   fsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr < ADDR_W'(NSEL)) |=> $stable(fsel_flat));

   // R4
   out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_OUT_SET)) |=> ((out_q & $past(wbits)) == $past(wbits)));

   // R5
   out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_OUT_CLR)) |=> ((out_q & $past(wbits)) == '0));

   // R8
   evt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(det)) == '0));

   // R9
   evt_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(A_EVENTS)) |=> ((evt_q & $past(wbits & ~det)) == '0));

   // R10
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q & $past(det)) == $past(det)));

   // R11
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(lvl_sync) != $past(lvl_prev)));

endmodule

bind gpio_evt_bank gpio_evt_bank_chk #(
   .NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wbits(wbits),
   .out_q(out_q), .evt_q(evt_q), .det(det), .lvl_sync(lvl_sync),
   .lvl_prev(lvl_prev), .fsel_flat(pin_fsel), .irq(irq)
);

// File: tb/test_gpio_evt_bank.sv
module test_gpio_evt_bank;

   localparam int NP = 32;
   localparam int NV = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_out, pin_oe;
   logic [NP*3-1:0] pin_fsel;
   logic          irq;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   gpio_evt_bank i_gpio_evt_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .pin_fsel(pin_fsel), .irq(irq)
   );

   // {write, address, data, expected read}
   localparam logic [68:0] VECS [NV] = '{
      {1'b1, 4'd0, 32'h0000_0009, 32'h0},           // R2 pins 0,1 -> output
      {1'b0, 4'd0, 32'h0,         32'h0000_0009},   // R2
      {1'b1, 4'd0, 32'h2000_0209, 32'h0},           // R3 pin3 out, pin9 alt 100
      {1'b0, 4'd0, 32'h0,         32'h2000_0209},   // R3
      {1'b1, 4'd3, 32'hFFFF_FFFF, 32'h0},           // R2 only pins 30,31 exist
      {1'b0, 4'd3, 32'h0,         32'h0000_003F},   // R2
      {1'b1, 4'd4, 32'h8000_0005, 32'h0},           // R4
      {1'b0, 4'd4, 32'h0,         32'h8000_0005},   // R4
      {1'b1, 4'd4, 32'h0000_0000, 32'h0},           // R4 zeros no effect
      {1'b0, 4'd5, 32'h0,         32'h8000_0005},   // R4 R5 readback
      {1'b1, 4'd5, 32'h0000_0004, 32'h0},           // R5
      {1'b0, 4'd4, 32'h0,         32'h8000_0001},   // R5
      {1'b1, 4'd5, 32'h0000_0000, 32'h0},           // R5 zeros no effect
      {1'b0, 4'd5, 32'h0,         32'h8000_0001},   // R5
      {1'b1, 4'd1, 32'h0000_0001, 32'h0},           // R3 pin10 -> output
      {1'b0, 4'd1, 32'h0,         32'h0000_0001},   // R2
      {1'b0, 4'd0, 32'h0,         32'h2000_0209}    // R3 other word untouched
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic pins(input logic [NP-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(posedge clk);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 10; a++) begin
         rd(4'(a), v);
         check("R1 reg", v, 32'h0);
      end
      check("R1 irq", {31'h0, irq}, 32'h0);
      check("R1 oe", pin_oe, 32'h0);
      check("R1 out", pin_out, 32'h0);

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VECS[i][68]) wr(VECS[i][67:64], VECS[i][63:32]);
         else begin
            rd(VECS[i][67:64], v);
            check("R2/R3/R4/R5 table", v, VECS[i][31:0]);
         end
      end

      // R6 pin-side outputs
      check("R6 oe", pin_oe, 32'h0000_040B);
      check("R6 out", pin_out, 32'h8000_0001);
      check("R3 pin9 code", {29'h0, pin_fsel[27 +: 3]}, 32'h4);
      check("R3 pin31 code", {29'h0, pin_fsel[93 +: 3]}, 32'h7);

      // R7 level latency (pin0 is in output mode, level still reads)
      @(negedge clk) pin_in = 32'h0000_0003;
      addr = 4'd6;
      @(posedge clk); #1;
      check("R7 one edge", rdata, 32'h0);
      @(posedge clk); #1;
      check("R7 two edges", rdata, 32'h0000_0003);
      @(negedge clk) pin_in = '0;
      repeat (4) @(posedge clk);
      wr(4'd9, 32'hFFFF_FFFF);

      // R8 enables: pin0 rise, pin1 fall, pin2 both
      wr(4'd7, 32'h0000_0005);
      wr(4'd8, 32'h0000_0006);
      pins(32'h0000_0003);
      rd(4'd9, v);
      check("R8 rise only pin0", v, 32'h0000_0001);
      check("R11 irq set", {31'h0, irq}, 32'h1);
      wr(4'd9, 32'h0);
      rd(4'd9, v);
      check("R9 zero write", v, 32'h0000_0001);
      wr(4'd9, 32'h0000_0001);
      rd(4'd9, v);
      check("R9 clear", v, 32'h0);
      check("R11 irq clear", {31'h0, irq}, 32'h0);
      pins(32'h0);
      rd(4'd9, v);
      check("R8 fall only pin1", v, 32'h0000_0002);
      wr(4'd9, 32'h0000_0002);
      pins(32'h0000_0004);
      rd(4'd9, v);
      check("R8 any edge rise", v, 32'h0000_0004);
      wr(4'd9, 32'h0000_0004);
      pins(32'h0);
      rd(4'd9, v);
      check("R8 any edge fall", v, 32'h0000_0004);
      wr(4'd9, 32'h0000_0004);

      // R10 clear meets a new edge on the same bit
      wr(4'd8, 32'h0000_0007);
      pins(32'h0000_0001);
      rd(4'd9, v);
      check("R10 precondition", v, 32'h0000_0001);
      @(negedge clk) pin_in = '0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1; addr = 4'd9; wdata = 32'h0000_0001;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
      rd(4'd9, v);
      check("R10 edge beats clear", v, 32'h0000_0001);
      check("R10 irq held", {31'h0, irq}, 32'h1);
      wr(4'd9, 32'h0000_0001);
      rd(4'd9, v);
      check("R10 later clear", v, 32'h0);
      check("R11 irq low", {31'h0, irq}, 32'h0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule